// File: doc/BRIEF.md
# Default Data Capability Access Checker

This block screens every instruction fetch, data load and data store against the default data capability (capability register 0) before the address goes on to translation. A request presents the capability's fields (a validity tag, a sealed flag, three permission bits, and the base, top and cursor bounds), the access kind, a 64-bit unsigned offset and a 2-bit access width. The block forms the virtual address as cursor plus offset. It then applies its checks in a fixed priority: tag first, then seal, then the permission that matches the access kind, and finally the bounds.

One clock after a request, the block reports a single registered response. The response either grants the access and returns the 64-bit virtual address, or refuses it and returns an 8-bit fault code. A refusal also carries register index 0, which the exception cause logic records. Translation and the memory access itself happen elsewhere.

Top module: `ddc_access_check`

## Requirements
- R1: While rst_n is low, all response outputs (rsp_valid, rsp_ok, rsp_fault, rsp_addr, rsp_code, rsp_regnum) are zero.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low after a cycle with req_valid low.
- R3: When rsp_valid is high, exactly one of rsp_ok and rsp_fault is high. When rsp_valid is low, rsp_ok, rsp_fault, rsp_addr and rsp_code are all zero.
- R4: A cleared cap_tag refuses the access with code 0x02, whatever the other fields hold.
- R5: A capability that has a set tag and a set cap_sealed is refused with code 0x03. This check outranks the permission and bounds checks.
- R6: acc_kind selects the permission that must be present. Fetch is 0 and needs cap_perm_exec, otherwise code 0x11. Load is 1 and needs cap_perm_load, otherwise code 0x12. Store is 2 and needs cap_perm_store, otherwise code 0x13. The reserved value 3 is checked exactly like a load.
- R7: The virtual address is cap_cursor + acc_offset, and the access size is 1 << acc_width bytes (1, 2, 4 or 8). A granted access returns the virtual address on rsp_addr, with rsp_code 0x00.
- R8: If the virtual address plus the size is greater than cap_top, the access is refused with code 0x01. The sum is formed without truncation, so an access ending exactly at cap_top is granted, cap_top = 2^64 admits the last bytes of the space, and a cursor plus offset that carries past 2^64 is refused.
- R9: If the virtual address is below cap_base, the access is refused with code 0x01. Tag, seal and permission faults take precedence over both bounds faults.
- R10: rsp_regnum is always 0x00. A refused access drives rsp_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability is sealed |
| cap_perm_exec | input | 1 | Execute permission |
| cap_perm_load | input | 1 | Load permission |
| cap_perm_store | input | 1 | Store permission |
| cap_base | input | 64 | Lowest permitted address |
| cap_top | input | 65 | One past the highest permitted address (may be 2^64) |
| cap_cursor | input | 64 | Capability cursor |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved (treated as load) |
| acc_offset | input | 64 | Unsigned offset added to the cursor |
| acc_width | input | 2 | log2 of the access size in bytes |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access granted |
| rsp_fault | output | 1 | Access refused |
| rsp_addr | output | 64 | Checked virtual address (zero on refusal) |
| rsp_code | output | 8 | Fault code (0x00 when granted) |
| rsp_regnum | output | 8 | Register index reported with a fault (always 0) |

## Verification
The bench targets the bound edges first. It drives accesses that end exactly at top, one byte past top, and inside the final eight bytes of the address space with top at 2^64. It also drives a cursor plus offset that carries past 2^64. A checker with a 64-bit end-address sum would either refuse the legal last access or wrap and grant the carrying one. The bench also stacks faults, combining a cleared tag with a seal, a seal with missing permissions, and a missing permission with out-of-bounds addresses, so a wrong priority shows up as the wrong code. The reserved access kind and gaps between requests catch a wrong permission mapping and stale response data.

// File: rtl/ddc_chk_pkg.sv
package ddc_chk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [7:0] {
    FLT_NONE   = 8'h00,
    FLT_LENGTH = 8'h01,
    FLT_TAG    = 8'h02,
    FLT_SEAL   = 8'h03,
    FLT_EXEC   = 8'h11,
    FLT_LOAD   = 8'h12,
    FLT_STORE  = 8'h13
  } fault_code_e;

  typedef struct packed {
    logic        tag_bad;
    logic        seal_bad;
    logic        perm_bad;
    fault_code_e perm_code;
    logic        above_top;
    logic        below_base;
  } chk_flags_t;

endpackage

// File: rtl/ddc_span_calc.sv
module ddc_span_calc #(
  parameter int AW = 64,
  parameter int WW = 2
) (
  input  logic [AW-1:0] cursor,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   top,
  input  logic [WW-1:0] width,
  output logic [AW:0]   vaddr,
  output logic          above_top,
  output logic          below_base
);
  // The end address needs one bit above the full-width virtual address.
  localparam int EW = AW + 2;

  logic [EW-1:0] size_bytes;
  logic [EW-1:0] end_addr;

  always_comb begin
    vaddr      = {1'b0, cursor} + {1'b0, offset};
    size_bytes = EW'(1) << width;
    end_addr   = {1'b0, vaddr} + size_bytes;
    above_top  = end_addr > {1'b0, top};
    below_base = vaddr < {1'b0, base};
  end

endmodule

// File: rtl/ddc_perm_gate.sv
module ddc_perm_gate
  import ddc_chk_pkg::*;
(
  input  logic        tag,
  input  logic        sealed,
  input  logic        perm_exec,
  input  logic        perm_load,
  input  logic        perm_store,
  input  logic [1:0]  kind,
  output logic        tag_bad,
  output logic        seal_bad,
  output logic        perm_bad,
  output fault_code_e perm_code
);
  localparam int NPERM = 3;

  logic [NPERM-1:0] have;
  logic [NPERM-1:0] need;

  assign have = {perm_store, perm_load, perm_exec};

  // One-hot selection of the permission this kind of access requires.
  for (genvar i = 0; i < NPERM; i++) begin : g_need
    if (i == 1) begin : g_load
      assign need[i] = (kind == 2'(ACC_LOAD)) || (kind == 2'(ACC_RSVD));
    end else begin : g_other
      assign need[i] = (kind == 2'(i));
    end
  end

  always_comb begin
    tag_bad   = !tag;
    seal_bad  = sealed;
    perm_bad  = |(need & ~have);
    perm_code = FLT_LOAD;
    unique case (1'b1)
      need[0]: perm_code = FLT_EXEC;
      need[2]: perm_code = FLT_STORE;
      default: perm_code = FLT_LOAD;
    endcase
  end

endmodule

// File: rtl/ddc_fault_sel.sv
module ddc_fault_sel
  import ddc_chk_pkg::*;
(
  input  chk_flags_t  flags,
  output logic        grant,
  output fault_code_e code
);
  // Fixed priority: tag, seal, permission, then either bound.
  always_comb begin
    grant = 1'b0;
    code  = FLT_NONE;
    if (flags.tag_bad) begin
      code = FLT_TAG;
    end else if (flags.seal_bad) begin
      code = FLT_SEAL;
    end else if (flags.perm_bad) begin
      code = flags.perm_code;
    end else if (flags.above_top || flags.below_base) begin
      code = FLT_LENGTH;
    end else begin
      grant = 1'b1;
    end
  end

endmodule

// File: rtl/ddc_access_check.sv
module ddc_access_check
  import ddc_chk_pkg::*;
#(
  parameter int AW = 64,
  parameter int WW = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          cap_tag,
  input  logic          cap_sealed,
  input  logic          cap_perm_exec,
  input  logic          cap_perm_load,
  input  logic          cap_perm_store,
  input  logic [AW-1:0] cap_base,
  input  logic [AW:0]   cap_top,
  input  logic [AW-1:0] cap_cursor,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_offset,
  input  logic [WW-1:0] acc_width,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_fault,
  output logic [AW-1:0] rsp_addr,
  output logic [CW-1:0] rsp_code,
  output logic [CW-1:0] rsp_regnum
);
  localparam logic [CW-1:0] REG_IDX = '0;

  logic [AW:0]  vaddr;
  chk_flags_t   flags;
  logic         grant;
  fault_code_e  code;

  ddc_span_calc #(.AW(AW), .WW(WW)) u_span (
    .cursor     (cap_cursor),
    .offset     (acc_offset),
    .base       (cap_base),
    .top        (cap_top),
    .width      (acc_width),
    .vaddr      (vaddr),
    .above_top  (flags.above_top),
    .below_base (flags.below_base)
  );

  ddc_perm_gate u_perm (
    .tag        (cap_tag),
    .sealed     (cap_sealed),
    .perm_exec  (cap_perm_exec),
    .perm_load  (cap_perm_load),
    .perm_store (cap_perm_store),
    .kind       (acc_kind),
    .tag_bad    (flags.tag_bad),
    .seal_bad   (flags.seal_bad),
    .perm_bad   (flags.perm_bad),
    .perm_code  (flags.perm_code)
  );

  ddc_fault_sel u_sel (
    .flags (flags),
    .grant (grant),
    .code  (code)
  );

  // Next-state logic.
  logic          valid_d, ok_d, fault_d, data_en;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] code_d;

  always_comb begin
    valid_d = req_valid;
    ok_d    = req_valid && grant;
    fault_d = req_valid && !grant;
    addr_d  = (req_valid && grant) ? vaddr[AW-1:0] : '0;
    code_d  = req_valid ? CW'(code) : '0;
    data_en = req_valid || rsp_valid;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_ok    <= ok_d;
      rsp_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_addr <= '0;
      rsp_code <= '0;
    end else if (data_en) begin
      rsp_addr <= addr_d;
      rsp_code <= code_d;
    end
  end

  assign rsp_regnum = REG_IDX;

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_ok, rsp_fault}));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_ok && !rsp_fault && rsp_code == '0 && rsp_addr == '0));
  // R4
  tag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cap_tag) |=> (rsp_fault && rsp_code == 8'h02));
  // R5
  seal_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cap_tag && cap_sealed) |=> (rsp_fault && rsp_code == 8'h03));
  // R10
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_addr == '0 && rsp_code != '0));

endmodule

// File: tb/ddc_access_check_bench.sv
module ddc_access_check_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        cap_tag = 1'b0, cap_sealed = 1'b0;
  logic        cap_perm_exec = 1'b0, cap_perm_load = 1'b0, cap_perm_store = 1'b0;
  logic [63:0] cap_base = '0, cap_cursor = '0, acc_offset = '0;
  logic [64:0] cap_top = '0;
  logic [1:0]  acc_kind = '0, acc_width = '0;
  logic        rsp_valid, rsp_ok, rsp_fault;
  logic [63:0] rsp_addr;
  logic [7:0]  rsp_code, rsp_regnum;

  always #2.5 clk = ~clk;

  ddc_access_check u_ddc_access_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cap_tag(cap_tag), .cap_sealed(cap_sealed),
    .cap_perm_exec(cap_perm_exec), .cap_perm_load(cap_perm_load),
    .cap_perm_store(cap_perm_store), .cap_base(cap_base), .cap_top(cap_top),
    .cap_cursor(cap_cursor), .acc_kind(acc_kind), .acc_offset(acc_offset),
    .acc_width(acc_width), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_code(rsp_code),
    .rsp_regnum(rsp_regnum)
  );

  typedef struct {
    logic        v;
    logic        ok;
    logic [7:0]  code;
    logic [63:0] addr;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  function automatic string code_req(logic [7:0] c);
    case (c)
      8'h02:   return "R4";
      8'h03:   return "R5";
      8'h11, 8'h12, 8'h13: return "R6";
      8'h01:   return "R8/R9 length";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural reference for the request currently on the inputs.
  function automatic exp_t model();
    exp_t e;
    logic [65:0] va, fin;
    logic        have;
    e.v = req_valid; e.ok = 1'b0; e.code = 8'h00; e.addr = '0;
    if (!req_valid) return e;
    va  = 66'(cap_cursor) + 66'(acc_offset);
    fin = va + (66'(1) << acc_width);
    case (acc_kind)
      2'd0:    have = cap_perm_exec;
      2'd2:    have = cap_perm_store;
      default: have = cap_perm_load;
    endcase
    if (!cap_tag)         e.code = 8'h02;
    else if (cap_sealed)  e.code = 8'h03;
    else if (!have)       e.code = (acc_kind == 2'd0) ? 8'h11 : (acc_kind == 2'd2) ? 8'h13 : 8'h12;
    else if (fin > 66'(cap_top) || va < 66'(cap_base)) e.code = 8'h01;
    else begin e.ok = 1'b1; e.addr = va[63:0]; end
    return e;
  endfunction

  // Compare last cycle's expectation, then present new inputs.
  task automatic compare_head();
    exp_t e;
    @(negedge clk);
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    chk("R2 valid", 64'(rsp_valid), 64'(e.v));
    chk("R3 ok", 64'(rsp_ok), 64'(e.ok));
    chk("R3 fault", 64'(rsp_fault), 64'(e.v && !e.ok));
    chk(code_req(e.code), 64'(rsp_code), 64'(e.code));
    chk(e.ok ? "R7 addr" : "R10 addr", rsp_addr, e.addr);
    chk("R10 regnum", 64'(rsp_regnum), 64'h0);
  endtask

  task automatic issue(logic t, logic s, logic px, logic pl, logic ps,
                       logic [63:0] b, logic [64:0] tp, logic [63:0] cur,
                       logic [1:0] k, logic [63:0] off, logic [1:0] w);
    compare_head();
    req_valid = 1'b1; cap_tag = t; cap_sealed = s;
    cap_perm_exec = px; cap_perm_load = pl; cap_perm_store = ps;
    cap_base = b; cap_top = tp; cap_cursor = cur;
    acc_kind = k; acc_offset = off; acc_width = w;
    exp_q.push_back(model());
  endtask

  task automatic idle();
    compare_head();
    req_valid = 1'b0;
    cap_cursor = 64'hdead_beef; acc_offset = 64'h55;
    exp_q.push_back(model());
  endtask

  localparam logic [64:0] TOP_MAX = 65'h1_0000_0000_0000_0000;

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 64'(rsp_valid), 0);
    chk("R1 ok", 64'(rsp_ok), 0);
    chk("R1 fault", 64'(rsp_fault), 0);
    chk("R1 addr", rsp_addr, 0);
    chk("R1 code", 64'(rsp_code), 0);
    chk("R1 regnum", 64'(rsp_regnum), 0);
    rst_n = 1'b1;
    exp_q.push_back(model());

    // R4: cleared tag beats seal and bounds
    issue(0, 1, 0, 0, 0, 64'h1000, 65'h2000, 64'h0, 2'd1, 64'h0, 2'd3);
    // R5: seal beats missing permission and bounds
    issue(1, 1, 0, 0, 0, 64'h1000, 65'h2000, 64'h0, 2'd2, 64'h0, 2'd0);
    // R6: each kind's permission, reserved kind as load
    issue(1, 0, 0, 1, 1, 64'h1000, 65'h2000, 64'h1000, 2'd0, 64'h4, 2'd2);
    issue(1, 0, 1, 0, 1, 64'h1000, 65'h2000, 64'h1000, 2'd1, 64'h4, 2'd2);
    issue(1, 0, 1, 1, 0, 64'h1000, 65'h2000, 64'h1000, 2'd2, 64'h4, 2'd2);
    issue(1, 0, 1, 0, 1, 64'h1000, 65'h2000, 64'h1000, 2'd3, 64'h4, 2'd2);
    issue(1, 0, 0, 1, 0, 64'h1000, 65'h2000, 64'h1000, 2'd3, 64'h4, 2'd2);
    // R9: permission fault outranks out-of-bounds
    issue(1, 0, 0, 1, 1, 64'h1000, 65'h2000, 64'h10, 2'd0, 64'h0, 2'd0);
    // R7: granted address
    issue(1, 0, 1, 1, 1, 64'h1000, 65'h2000, 64'h1000, 2'd1, 64'h10, 2'd3);
    idle();
    // R8: end exactly at top, then one past
    issue(1, 0, 1, 1, 1, 64'h1000, 65'h2000, 64'h1ff8, 2'd2, 64'h0, 2'd3);
    issue(1, 0, 1, 1, 1, 64'h1000, 65'h2000, 64'h1ff8, 2'd2, 64'h1, 2'd3);
    issue(1, 0, 1, 1, 1, 64'h1000, 65'h2000, 64'h1fff, 2'd1, 64'h0, 2'd0);
    // R8: top at 2^64, last bytes, and carry past 2^64
    issue(1, 0, 1, 1, 1, 64'h0, TOP_MAX, 64'hffff_ffff_ffff_fff8, 2'd1, 64'h0, 2'd3);
    issue(1, 0, 1, 1, 1, 64'h0, TOP_MAX, 64'hffff_ffff_ffff_fff0, 2'd1, 64'hf, 2'd0);
    issue(1, 0, 1, 1, 1, 64'h0, TOP_MAX, 64'hffff_ffff_ffff_fff8, 2'd1, 64'h4, 2'd3);
    issue(1, 0, 1, 1, 1, 64'h0, TOP_MAX, 64'hffff_ffff_ffff_ffff, 2'd1, 64'h10, 2'd0);
    // R9: below base
    issue(1, 0, 1, 1, 1, 64'h1000, 65'h2000, 64'h0800, 2'd1, 64'h7ff, 2'd0);
    issue(1, 0, 1, 1, 1, 64'h1000, 65'h2000, 64'h0800, 2'd1, 64'h800, 2'd0);
    idle(); idle();

    // Mixed random traffic, R2/R3 gaps included
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 4) == 0) idle();
      else begin
        logic [63:0] b, cur, off;
        logic [64:0] tp;
        b   = 64'($urandom_range(0, 32'h0010_0000));
        tp  = 65'(b) + 65'($urandom_range(0, 4096));
        cur = b - 64'($urandom_range(0, 64));
        off = 64'($urandom_range(0, 4200));
        if ($urandom_range(0, 9) == 0) begin
          tp  = TOP_MAX;
          cur = 64'hffff_ffff_ffff_ff00 + 64'($urandom_range(0, 255));
        end
        issue($urandom_range(0, 19) != 0, $urandom_range(0, 9) == 0,
              $urandom_range(0, 6) != 0, $urandom_range(0, 6) != 0,
              $urandom_range(0, 6) != 0, b, tp, cur,
              2'($urandom_range(0, 3)), off, 2'($urandom_range(0, 3)));
      end
    end
    idle(); idle();
    compare_head();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule